// File: doc/BRIEF.md
# Register-Mapped Interrupt Aggregator

The block gathers up to 32 interrupt request lines into one interrupt output for a processor. Each request line owns one bit position in a 32-bit word. A rising edge on a request line is captured in a status word. The status word is masked by an enable word, and the masked result (the pending word) is combined into a single registered output, gated by a master switch.

Software reaches the block through a single-cycle register port made of a word address, a write strobe, write data and combinational read data. It can replace the whole enable word, or set or clear selected enable bits through two write-only alias addresses. It acknowledges sources by writing a bit mask. A two-bit control register holds the master gate and a one-way switch that hands status updates from software to hardware. Before that switch is thrown, software may load the status word directly, for example to clear it during start-up.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the status, enable and control registers are zero, `irq_out` is 0, and every address reads 0.
- R2: With hardware mode on, a 0-to-1 transition of `irq_req[i]` sets status bit i at the next clock edge. A request held high is not captured again after it is acknowledged. A request that falls and rises again is captured again.
- R3: A write to the acknowledge address (3) clears every status bit whose write-data bit is 1 and leaves the other status bits unchanged.
- R4: When a request rises in the same cycle as an acknowledge of that bit, the status bit ends up set.
- R5: A write to the enable address (2) replaces the whole enable word. Writing 0 masks every source. The enable word reads back at address 2.
- R6: A write to the set alias (4) sets the enable bits whose data bits are 1. A write to the clear alias (5) clears them. In both cases all other enable bits keep their values.
- R7: The pending address (1) reads status AND enable.
- R8: The status address (0) reads the status word. While hardware mode is off, a write there loads the status word and request edges are not captured. While hardware mode is on, such writes are ignored.
- R9: The control register at address 6 has bit 0 = master enable and bit 1 = hardware mode, and it reads back in those positions. Hardware mode, once set, stays set until reset.
- R10: `irq_out` is a register. One cycle after a state change it equals master enable AND (pending word != 0).
- R11: Addresses 3, 4, 5 and 7 read 0. A write to address 1 or address 7 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NUM_SRC | Interrupt request lines, one per source |
| bus_addr | input | 3 | Word address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Combined interrupt to the processor |

## Verification
Register writes and request edges take effect at the next clock edge. Read data is combinational, so a read presented in the cycle after a write or an edge already shows the new state. `irq_out` lags the register state by one more edge. The bench tags each expected value with the cycle count at which it is due. It then checks the output on the falling edge of that cycle: either the same cycle, for a read, or one cycle later, for `irq_out`. For `irq_out` it also checks the old value in the intervening cycle, which pins the latency down exactly.

// File: rtl/vic_pkg.sv
package vic_pkg;

  typedef enum logic [2:0] {
    A_STAT = 3'd0,
    A_PEND = 3'd1,
    A_ENAB = 3'd2,
    A_ACK  = 3'd3,
    A_ESET = 3'd4,
    A_ECLR = 3'd5,
    A_CTRL = 3'd6,
    A_RSVD = 3'd7
  } vic_addr_e;

  localparam int CTRL_ME_BIT = 0;
  localparam int CTRL_HW_BIT = 1;

  typedef struct packed {
    logic stat_wr;
    logic enab_wr;
    logic ack_wr;
    logic eset_wr;
    logic eclr_wr;
    logic ctrl_wr;
  } vic_wr_t;

endpackage

// File: rtl/vic_bus_decode.sv
module vic_bus_decode
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input  logic [2:0]         addr,
  input  logic               we,
  input  logic [NUM_SRC-1:0] stat,
  input  logic [NUM_SRC-1:0] enab,
  input  logic               master_en,
  input  logic               hw_mode,
  output vic_wr_t            wr,
  output logic [DATA_W-1:0]  rdata
);

  vic_addr_e sel;
  assign sel = vic_addr_e'(addr);

  // write strobes: one per writable address
  always_comb begin
    wr = '0;
    if (we) begin
      unique case (sel)
        A_STAT:  wr.stat_wr = 1'b1;
        A_ENAB:  wr.enab_wr = 1'b1;
        A_ACK:   wr.ack_wr  = 1'b1;
        A_ESET:  wr.eset_wr = 1'b1;
        A_ECLR:  wr.eclr_wr = 1'b1;
        A_CTRL:  wr.ctrl_wr = 1'b1;
        default: wr = '0;
      endcase
    end
  end

  // read mux, zero padded to the bus width
  always_comb begin
    rdata = '0;
    unique case (sel)
      A_STAT: rdata[NUM_SRC-1:0] = stat;
      A_PEND: rdata[NUM_SRC-1:0] = stat & enab;
      A_ENAB: rdata[NUM_SRC-1:0] = enab;
      A_CTRL: begin
        rdata[CTRL_ME_BIT] = master_en;
        rdata[CTRL_HW_BIT] = hw_mode;
      end
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/vic_status_bank.sv
module vic_status_bank #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hw_mode,
  input  logic [NUM_SRC-1:0] req,
  input  logic               sw_wr,
  input  logic               ack_wr,
  input  logic [NUM_SRC-1:0] data,
  output logic [NUM_SRC-1:0] stat_q,
  output logic [NUM_SRC-1:0] rise_o
);

  logic [NUM_SRC-1:0] req_prev;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    logic clr_i;
    assign rise_o[i] = req[i] & ~req_prev[i];
    assign clr_i     = ack_wr & data[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        req_prev[i] <= 1'b0;
        stat_q[i]   <= 1'b0;
      end else begin
        req_prev[i] <= req[i];
        if (hw_mode) begin
          // a captured edge outranks an acknowledge in the same cycle
          stat_q[i] <= rise_o[i] | (stat_q[i] & ~clr_i);
        end else if (sw_wr) begin
          stat_q[i] <= data[i];
        end else if (clr_i) begin
          stat_q[i] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/vic_enable_bank.sv
module vic_enable_bank #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_full,
  input  logic               wr_set,
  input  logic               wr_clr,
  input  logic [NUM_SRC-1:0] data,
  output logic [NUM_SRC-1:0] en_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_full) begin
      en_q <= data;
    end else if (wr_set) begin
      en_q <= en_q | data;
    end else if (wr_clr) begin
      en_q <= en_q & ~data;
    end
  end

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic [2:0]         bus_addr,
  input  logic               bus_we,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_out
);

  vic_wr_t            wr;
  logic [NUM_SRC-1:0] wmask;
  logic [NUM_SRC-1:0] stat_q;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] req_rise;
  logic               master_en;
  logic               hw_mode;

  assign wmask = bus_wdata[NUM_SRC-1:0];

  vic_bus_decode #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_dec (
    .addr      (bus_addr),
    .we        (bus_we),
    .stat      (stat_q),
    .enab      (en_q),
    .master_en (master_en),
    .hw_mode   (hw_mode),
    .wr        (wr),
    .rdata     (bus_rdata)
  );

  vic_status_bank #(.NUM_SRC(NUM_SRC)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_mode (hw_mode),
    .req     (irq_req),
    .sw_wr   (wr.stat_wr),
    .ack_wr  (wr.ack_wr),
    .data    (wmask),
    .stat_q  (stat_q),
    .rise_o  (req_rise)
  );

  vic_enable_bank #(.NUM_SRC(NUM_SRC)) u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_full (wr.enab_wr),
    .wr_set  (wr.eset_wr),
    .wr_clr  (wr.eclr_wr),
    .data    (wmask),
    .en_q    (en_q)
  );

  // control register: master gate plus one-way hardware-mode switch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_en <= 1'b0;
      hw_mode   <= 1'b0;
    end else if (wr.ctrl_wr) begin
      master_en <= bus_wdata[CTRL_ME_BIT];
      hw_mode   <= hw_mode | bus_wdata[CTRL_HW_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_out <= 1'b0;
    end else begin
      irq_out <= master_en & (|(stat_q & en_q));
    end
  end

endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         bus_addr,
  input logic               bus_we,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic               irq_out,
  input logic [NUM_SRC-1:0] wmask,
  input logic [NUM_SRC-1:0] stat_q,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] req_rise,
  input logic               master_en,
  input logic               hw_mode
);

  p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd3) |=>
      ((stat_q & $past(wmask) & ~$past(req_rise)) == '0));

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd3 && hw_mode) |=>
      ((stat_q & $past(req_rise)) == $past(req_rise)));

  p_eset_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd4) |=>
      (((en_q & $past(wmask)) == $past(wmask)) &&
       ((en_q & ~$past(wmask)) == ($past(en_q) & ~$past(wmask)))));

  p_eclr_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd5) |=>
      (((en_q & $past(wmask)) == '0) &&
       ((en_q & ~$past(wmask)) == ($past(en_q) & ~$past(wmask)))));

  p_pend_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd1) |-> (bus_rdata[NUM_SRC-1:0] == (stat_q & en_q)));

  p_sw_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_mode && bus_we && bus_addr == 3'd0) |=>
      ((stat_q & ~$past(stat_q)) == ($past(req_rise) & ~$past(stat_q))));

  p_hw_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hw_mode |=> hw_mode);

  p_out_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == ($past(master_en) && ($past(stat_q & en_q) != '0))));

  p_alias_read_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd3 || bus_addr == 3'd4 || bus_addr == 3'd5 || bus_addr == 3'd7)
      |-> (bus_rdata == '0));

endmodule

bind vec_irq_ctrl vic_checker #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_vic_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .wmask     (wmask),
  .stat_q    (stat_q),
  .en_q      (en_q),
  .req_rise  (req_rise),
  .master_en (master_en),
  .hw_mode   (hw_mode)
);

// File: tb/vec_irq_ctrl_bench.sv
module vec_irq_ctrl_bench;

  localparam int N = 32;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq_req = '0;
  logic [2:0]   bus_addr = 3'd0;
  logic         bus_we = 1'b0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic         irq_out;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  typedef struct {
    int          due;
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vec_irq_ctrl #(.NUM_SRC(N), .DATA_W(W)) u_vec_irq_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out)
  );

  // monitor: compares each queued item in the cycle it is due
  initial begin
    forever begin
      @(negedge clk);
      #1;
      for (int i = sb.size() - 1; i >= 0; i--) begin
        if (sb[i].due == cyc) begin
          logic [31:0] act;
          act = sb[i].is_irq ? {31'd0, irq_out} : bus_rdata;
          checks++;
          if (act !== sb[i].exp) begin
            fails++;
            $display("FAIL %s cyc=%0d %s actual=%h expected=%h", sb[i].tag, cyc,
                     sb[i].is_irq ? "irq_out" : "rdata", act, sb[i].exp);
          end
          sb.delete(i);
        end
      end
    end
  end

  // driver tasks: each starts and ends on a falling edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wr_req(input logic [2:0] a, input logic [31:0] d, input logic [N-1:0] r);
    irq_req = r;
    wr(a, d);
  endtask

  task automatic set_req(input logic [N-1:0] r);
    irq_req = r;
    @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    item_t it;
    bus_addr = a;
    it.due = cyc; it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic exp_irq(input bit v, input int lag, input string tag);
    item_t it;
    it.due = cyc + lag; it.is_irq = 1'b1; it.exp = {31'd0, v}; it.tag = tag;
    sb.push_back(it);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    exp_irq(1'b0, 0, "R1");
    rd(3'd0, 32'h0, "R1"); rd(3'd1, 32'h0, "R1");
    rd(3'd2, 32'h0, "R1"); rd(3'd6, 32'h0, "R1");

    // R8 software-loaded status, edges ignored in software mode
    wr(3'd0, 32'h0000_00F0); rd(3'd0, 32'h0000_00F0, "R8");
    set_req(32'h1); rd(3'd0, 32'h0000_00F0, "R8"); set_req(32'h0);
    // R3 acknowledge clears only the ones
    wr(3'd3, 32'h0000_0030); rd(3'd0, 32'h0000_00C0, "R3");

    // R5 / R6 enable word and aliases
    wr(3'd2, 32'hA5A5_0000); rd(3'd2, 32'hA5A5_0000, "R5");
    wr(3'd4, 32'h0000_0001); rd(3'd2, 32'hA5A5_0001, "R6");
    wr(3'd5, 32'h8000_0000); rd(3'd2, 32'h25A5_0001, "R6");
    wr(3'd2, 32'h0);         rd(3'd2, 32'h0, "R5");

    // R7 pending = status & enable
    wr(3'd0, 32'h0000_0F0F); wr(3'd2, 32'h0000_00FF);
    rd(3'd1, 32'h0000_000F, "R7");

    // R11 read-only / unused addresses
    wr(3'd1, 32'h0000_FFFF);
    rd(3'd1, 32'h0000_000F, "R11"); rd(3'd0, 32'h0000_0F0F, "R11");
    rd(3'd2, 32'h0000_00FF, "R11");
    wr(3'd7, 32'hFFFF_FFFF); rd(3'd0, 32'h0000_0F0F, "R11");
    rd(3'd3, 32'h0, "R11"); rd(3'd4, 32'h0, "R11");
    rd(3'd5, 32'h0, "R11"); rd(3'd7, 32'h0, "R11");

    // R10 master gate with one cycle of latency
    exp_irq(1'b0, 0, "R10");
    wr(3'd6, 32'h1);
    exp_irq(1'b0, 0, "R10"); exp_irq(1'b1, 1, "R10");
    rd(3'd6, 32'h1, "R9");
    wr(3'd6, 32'h0);
    exp_irq(1'b1, 0, "R10"); exp_irq(1'b0, 1, "R10");
    @(negedge clk);
    wr(3'd3, 32'hFFFF_FFFF); rd(3'd0, 32'h0, "R3");

    // R9 hardware mode is sticky
    wr(3'd6, 32'h2); rd(3'd6, 32'h2, "R9");
    wr(3'd6, 32'h3); rd(3'd6, 32'h3, "R9");
    wr(3'd6, 32'h1); rd(3'd6, 32'h3, "R9");
    // R8 status writes ignored in hardware mode
    wr(3'd0, 32'h0000_FFFF); rd(3'd0, 32'h0, "R8");

    // R2 edge capture, held level, re-capture
    set_req(32'h8);
    exp_irq(1'b1, 1, "R10");
    rd(3'd0, 32'h8, "R2"); rd(3'd1, 32'h8, "R7");
    wr(3'd3, 32'h8);
    exp_irq(1'b0, 1, "R10");
    rd(3'd0, 32'h0, "R3"); rd(3'd0, 32'h0, "R2");
    set_req(32'h0); set_req(32'h8); rd(3'd0, 32'h8, "R2");
    set_req(32'h22); rd(3'd0, 32'h2A, "R2");
    wr(3'd3, 32'h2A); rd(3'd0, 32'h0, "R3");

    // R4 rise and acknowledge in the same cycle
    set_req(32'h20); set_req(32'h22); rd(3'd0, 32'h2, "R2");
    wr_req(3'd3, 32'h82, 32'hA2); rd(3'd0, 32'h80, "R4");

    // R7 masked source latched but not pending
    set_req(32'h0010_00A2);
    rd(3'd0, 32'h0010_0080, "R7"); rd(3'd1, 32'h80, "R7");

    // R10 master off in hardware mode
    wr(3'd6, 32'h2);
    exp_irq(1'b0, 1, "R10");
    rd(3'd6, 32'h2, "R9");
    wr(3'd2, 32'h0); rd(3'd1, 32'h0, "R5");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL scoreboard %0d items never checked", sb.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule